// File: doc/BRIEF.md
# Sleep and Wake-Up Reset-Cause Controller

This block governs the power-down state of a small microcontroller core. When the core executes its sleep instruction it raises a one-cycle strobe, and the controller enters sleep on the next clock edge. On entry it shuts off the oscillator enable and holds every I/O driver in whatever state it had, whether high, low or high-impedance. It also pulses a watchdog clear and updates two status flags. The watchdog counter keeps running. The watchdog counter, the comparator and the CPU sit outside this block.

While asleep, four wake sources are watched, and each one has its own enable. The first is the external reset pin, active low. The second is a watchdog time-out. The third is a change on any of the wake pins compared with a reference that was captured at the last port read. The fourth is a change of the comparator output since sleep was entered. Any wake ends sleep with a fixed-length internal reset pulse rather than a resume. This reset is a separate output and never drives the external pin. Sticky status flags record why the reset happened, and they survive that pulse so firmware can read them afterwards. Because the pin reference is only refreshed by a port read, firmware that sleeps again without reading the port wakes at once.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: With `asleep`=0, `core_rst`=0 and `sleep_req`=1 at a clock edge, the next cycle shows `asleep`=1, `pd_flag`=0, `to_flag`=1 and a one-cycle `wdt_clr`=1.
- R2: While `asleep`=1, `osc_en`=0 and `io_hold`=1. A `sleep_req` while already asleep, or while `core_rst`=1, has no effect.
- R3: Pin and comparator inputs and `mclr_n` pass through a two-flop synchronizer. With `mclr_en`=1, a low synchronized `mclr_n` while asleep wakes the block at the following edge, and `to_flag` stays 1.
- R4: With `wdt_en`=1, `wdt_timeout`=1 while asleep wakes the block at that edge and sets `to_flag` to 0. Other wake causes leave `to_flag` unchanged.
- R5: `port_rd`=1 loads the synchronized `wake_pins` into a reference. With `pin_wake_en`=1, any difference while asleep wakes the block and sets `pin_wake_flag`.
- R6: The synchronized `cmp_out` is captured at sleep entry. With `cmp_wake_en`=1, a difference while asleep wakes the block and sets `cmp_wake_flag`.
- R7: Each wake clears `asleep` on the next cycle. In that same cycle `core_rst` rises and stays high for exactly 4 consecutive cycles, and `wdt_clr` is high for one cycle.
- R8: Entering sleep while the pin reference still differs from the pins, with pin wake enabled, wakes the block one cycle after entry.
- R9: Power-on `rst` gives `asleep`=0, `core_rst`=0, `wdt_clr`=0, `to_flag`=1, `pd_flag`=1, and both wake flags 0. Only `rst` clears the wake flags and sets `pd_flag`; a wake reset does neither.
- R10: A wake source whose enable is 0 never wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| sleep_req | input | 1 | Sleep instruction strobe from the core |
| port_rd | input | 1 | Port read strobe; reloads the pin reference |
| wake_pins | input | N_PINS | Pins watched for change (default 3) |
| cmp_out | input | 1 | Comparator output |
| mclr_n | input | 1 | External reset pin level, active low |
| mclr_en | input | 1 | Pin is configured as a reset |
| wdt_en | input | 1 | Watchdog wake enable |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| pin_wake_en | input | 1 | Pin-change wake enable |
| cmp_wake_en | input | 1 | Comparator wake enable |
| asleep | output | 1 | Block is in sleep |
| osc_en | output | 1 | Oscillator driver enable |
| io_hold | output | 1 | Freeze I/O drivers |
| core_rst | output | 1 | Internal device reset pulse |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| to_flag | output | 1 | Time-out status, 0 after a watchdog wake |
| pd_flag | output | 1 | Power-down status, 0 once sleep was entered |
| pin_wake_flag | output | 1 | Sticky pin-change wake cause |
| cmp_wake_flag | output | 1 | Sticky comparator wake cause |

## Verification
A wrong pin or comparator reference does not fail quietly. It either wakes the block one cycle after sleep entry, when it should have stayed asleep, or it keeps the block asleep when a change should have woken it. Either case shows on `asleep` and `core_rst` within three cycles of the input edge. Wrong flag state appears on the status outputs in the cycle after the wake edge, and it stays visible because the flags are sticky. A miscounted reset length shows when `core_rst` falls.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;
  typedef struct packed {
    logic mclr;
    logic wdt;
    logic pin;
    logic cmp;
  } wake_src_t;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter bit RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] INIT = {W{RST_ONE}};
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_ref_cmp.sv
module swc_ref_cmp #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] cur,
  output logic         differs
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)       ref_q <= '0;
    else if (load) ref_q <= cur;
  end

  assign differs = (cur != ref_q);
endmodule

// File: rtl/swc_rst_pulse.sv
module swc_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOADV = CW'(LEN);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= LOADV;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int N_PINS = 3,
  parameter int RST_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              port_rd,
  input  logic [N_PINS-1:0] wake_pins,
  input  logic              cmp_out,
  input  logic              mclr_n,
  input  logic              mclr_en,
  input  logic              wdt_en,
  input  logic              wdt_timeout,
  input  logic              pin_wake_en,
  input  logic              cmp_wake_en,
  output logic              asleep,
  output logic              osc_en,
  output logic              io_hold,
  output logic              core_rst,
  output logic              wdt_clr,
  output logic              to_flag,
  output logic              pd_flag,
  output logic              pin_wake_flag,
  output logic              cmp_wake_flag
);
  logic [N_PINS-1:0] pins_s;
  logic              cmp_s, mclr_s;
  logic              pin_diff, cmp_diff;
  logic              enter, wake;
  wake_src_t         src;

  swc_sync #(.W(N_PINS), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(wake_pins), .q(pins_s));
  swc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b0)) u_cmp_sync (
    .clk(clk), .rst(rst), .d(cmp_out), .q(cmp_s));
  swc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_ONE(1'b1)) u_mclr_sync (
    .clk(clk), .rst(rst), .d(mclr_n), .q(mclr_s));

  // pin reference follows port reads; comparator reference is taken at sleep entry
  swc_ref_cmp #(.W(N_PINS)) u_pin_ref (
    .clk(clk), .rst(rst), .load(port_rd), .cur(pins_s), .differs(pin_diff));
  swc_ref_cmp #(.W(1)) u_cmp_ref (
    .clk(clk), .rst(rst), .load(enter), .cur(cmp_s), .differs(cmp_diff));

  swc_rst_pulse #(.LEN(RST_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .start(wake), .active(core_rst));

  always_comb begin
    src.mclr = mclr_en & ~mclr_s;
    src.wdt  = wdt_en & wdt_timeout;
    src.pin  = pin_wake_en & pin_diff;
    src.cmp  = cmp_wake_en & cmp_diff;
  end

  assign enter = ~asleep & sleep_req & ~core_rst;
  assign wake  = asleep & (src != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep        <= 1'b0;
      wdt_clr       <= 1'b0;
      to_flag       <= 1'b1;
      pd_flag       <= 1'b1;
      pin_wake_flag <= 1'b0;
      cmp_wake_flag <= 1'b0;
    end else begin
      wdt_clr <= enter | wake;
      if (enter) begin
        asleep  <= 1'b1;
        to_flag <= 1'b1;
        pd_flag <= 1'b0;
      end else if (wake) begin
        asleep <= 1'b0;
        if (src.wdt) to_flag <= 1'b0;
        if (src.pin) pin_wake_flag <= 1'b1;
        if (src.cmp) cmp_wake_flag <= 1'b1;
      end
    end
  end

  assign osc_en  = ~asleep;
  assign io_hold = asleep;
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic clk,
  input logic rst,
  input logic sleep_req,
  input logic asleep,
  input logic core_rst,
  input logic wdt_clr,
  input logic to_flag,
  input logic pd_flag,
  input logic pin_wake_flag,
  input logic cmp_wake_flag
);
  int run_len;

  always_ff @(posedge clk) begin
    if (rst)           run_len <= 0;
    else if (core_rst) run_len <= run_len + 1;
    else               run_len <= 0;
  end

  a_r1_enter: assert property (@(posedge clk) disable iff (rst)
    (!asleep && sleep_req && !core_rst) |=> (asleep && !pd_flag && to_flag && wdt_clr));

  a_r7_wake_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> (core_rst && wdt_clr));

  a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> (run_len == RST_CYCLES));

  a_r9_pd_sticky: assert property (@(posedge clk) disable iff (rst)
    !pd_flag |=> !pd_flag);

  a_r5_pin_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    pin_wake_flag |=> pin_wake_flag);

  a_r6_cmp_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    cmp_wake_flag |=> cmp_wake_flag);

  a_r4_to_only_on_wake: assert property (@(posedge clk) disable iff (rst)
    $fell(to_flag) |-> $fell(asleep));
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .asleep(asleep),
  .core_rst(core_rst), .wdt_clr(wdt_clr), .to_flag(to_flag), .pd_flag(pd_flag),
  .pin_wake_flag(pin_wake_flag), .cmp_wake_flag(cmp_wake_flag));

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 0, port_rd = 0, cmp_out = 0, mclr_n = 1;
  logic mclr_en = 1, wdt_en = 1, wdt_timeout = 0, pin_wake_en = 1, cmp_wake_en = 1;
  logic [2:0] wake_pins = 3'b000;
  logic asleep, osc_en, io_hold, core_rst, wdt_clr, to_flag, pd_flag, pin_wake_flag, cmp_wake_flag;

  int total = 0, bad = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  sleep_wake_ctrl uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .port_rd(port_rd),
    .wake_pins(wake_pins), .cmp_out(cmp_out), .mclr_n(mclr_n), .mclr_en(mclr_en),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .pin_wake_en(pin_wake_en),
    .cmp_wake_en(cmp_wake_en), .asleep(asleep), .osc_en(osc_en), .io_hold(io_hold),
    .core_rst(core_rst), .wdt_clr(wdt_clr), .to_flag(to_flag), .pd_flag(pd_flag),
    .pin_wake_flag(pin_wake_flag), .cmp_wake_flag(cmp_wake_flag));

  // behavioural reference model
  int p_hist[$], c_hist[$], m_hist[$];
  int m_ref, m_cref, m_rcnt;
  bit m_asleep, m_to, m_pd, m_pf, m_cf, m_wclr;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      p_hist = '{0, 0}; c_hist = '{0, 0}; m_hist = '{1, 1};
      m_ref = 0; m_cref = 0; m_rcnt = 0;
      m_asleep = 0; m_to = 1; m_pd = 1; m_pf = 0; m_cf = 0; m_wclr = 0;
    end else begin
      bit wm, ww, wp, wc, wake, enter;
      wm = mclr_en && (m_hist[1] == 0);
      ww = wdt_en && wdt_timeout;
      wp = pin_wake_en && (p_hist[1] != m_ref);
      wc = cmp_wake_en && (c_hist[1] != m_cref);
      wake  = m_asleep && (wm || ww || wp || wc);
      enter = !m_asleep && sleep_req && (m_rcnt == 0);
      if (wake) m_rcnt = 4; else if (m_rcnt > 0) m_rcnt--;
      if (port_rd) m_ref = p_hist[1];
      if (enter) begin m_cref = c_hist[1]; m_asleep = 1; m_to = 1; m_pd = 0; end
      else if (wake) begin
        m_asleep = 0;
        if (ww) m_to = 0;
        if (wp) m_pf = 1;
        if (wc) m_cf = 1;
      end
      m_wclr = enter || wake;
      void'(p_hist.pop_back()); p_hist.push_front(int'(wake_pins));
      void'(c_hist.pop_back()); c_hist.push_front(int'(cmp_out));
      void'(m_hist.pop_back()); m_hist.push_front(int'(mclr_n));
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 asleep", asleep, m_asleep);
      chk("R2 osc_en", osc_en, !m_asleep);
      chk("R2 io_hold", io_hold, m_asleep);
      chk("R7 core_rst", core_rst, m_rcnt != 0);
      chk("R1 wdt_clr", wdt_clr, m_wclr);
      chk("R4 to_flag", to_flag, m_to);
      chk("R1 pd_flag", pd_flag, m_pd);
      chk("R5 pin_wake_flag", pin_wake_flag, m_pf);
      chk("R6 cmp_wake_flag", cmp_wake_flag, m_cf);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1; cyc(1); sleep_req = 0;
  endtask

  task automatic pulse_rd();
    port_rd = 1; cyc(1); port_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    // R9 reset state
    chk("R9 reset asleep", asleep, 0);
    chk("R9 reset to", to_flag, 1);
    chk("R9 reset pd", pd_flag, 1);
    chk("R9 reset core_rst", core_rst, 0);
    rst = 0; cyc(3);

    // R1, R3: external reset pin wake
    pulse_sleep(); cyc(5);
    chk("R2 stays asleep", asleep, 1);
    mclr_n = 0; cyc(3); mclr_n = 1; cyc(10);
    chk("R3 woke by pin reset", asleep, 0);
    chk("R3 to kept", to_flag, 1);
    chk("R1 pd cleared", pd_flag, 0);

    // R4: watchdog wake
    pulse_sleep(); cyc(3);
    wdt_timeout = 1; cyc(1); wdt_timeout = 0; cyc(10);
    chk("R4 to cleared", to_flag, 0);

    // R5, R8: pin change and stale reference
    pulse_rd(); pulse_sleep(); cyc(4);
    wake_pins = 3'b010; cyc(10);
    chk("R5 pin wake flag", pin_wake_flag, 1);
    chk("R4 to set by entry", to_flag, 1);
    pulse_sleep(); cyc(8);
    chk("R8 immediate rewake", asleep, 0);
    pulse_rd(); pulse_sleep(); cyc(10);
    chk("R5 no change stays asleep", asleep, 1);
    wake_pins = 3'b000; cyc(10);
    chk("R5 change back wakes", asleep, 0);
    pulse_rd(); cyc(3);

    // R6: comparator change
    cmp_out = 1; cyc(4);
    pulse_sleep(); cyc(8);
    chk("R6 steady comparator asleep", asleep, 1);
    cmp_out = 0; cyc(10);
    chk("R6 comparator wake flag", cmp_wake_flag, 1);

    // R10: disabled sources
    mclr_en = 0; wdt_en = 0; pin_wake_en = 0; cmp_wake_en = 0;
    pulse_sleep(); cyc(3);
    wake_pins = 3'b101; cmp_out = 1; mclr_n = 0; wdt_timeout = 1; cyc(2);
    wdt_timeout = 0; cyc(10);
    chk("R10 disabled sources ignored", asleep, 1);
    mclr_n = 1; wdt_en = 1; cyc(3);
    wdt_timeout = 1; cyc(1); wdt_timeout = 0;
    // R2: sleep strobe during reset pulse is ignored
    cyc(1); pulse_sleep(); cyc(10);
    chk("R2 sleep ignored during reset", asleep, 0);
    pulse_sleep(); cyc(3);
    pulse_sleep(); cyc(5);
    chk("R2 repeated sleep harmless", asleep, 1);
    wdt_timeout = 1; cyc(1); wdt_timeout = 0; cyc(10);

    // R9: flags survive wake, cleared by power-on reset
    chk("R9 pin flag survives", pin_wake_flag, 1);
    chk("R9 cmp flag survives", cmp_wake_flag, 1);
    rst = 1; cyc(2);
    chk("R9 pin flag cleared", pin_wake_flag, 0);
    chk("R9 cmp flag cleared", cmp_wake_flag, 0);
    chk("R9 pd set", pd_flag, 1);
    rst = 0; cyc(5);
    finish_run();
  end
endmodule